// File: doc/BRIEF.md
# ASCII to Keyboard Scan Matrix Translator

This block turns a stream of ASCII bytes into the key state of an emulated keyboard scan matrix. The matrix is six 16-bit words that downstream logic reads as if a real key matrix had been scanned. The block works in scan periods. Each pulse on `scan_tick` marks one period. On that pulse the previous key state is released and at most one character is applied.

Bytes arrive on a valid/ready stream. A byte is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while `scan_tick` is high and the internal re-injection slot is empty. A source that sees `in_ready` low must hold `in_valid` and `in_data` unchanged until the byte is taken.

Some characters need a modifier key, for example uppercase letters, control codes and shifted punctuation. For these the block sets the modifier bit and stores the base character in a one-entry slot. That character is applied on the next scan tick, ahead of any new input. Cursor keys arrive as the three-byte escape sequence 0x1B, '[', letter, and a small state machine decodes them. Every scan tick that changes what a scanner would see produces a one-cycle `key_event_o` pulse.

Top module: `ascii_keymatrix`

## Requirements
- R1: After reset, all six matrix words are zero and `key_event_o` is low.
- R2: On each scan tick, every word is first cleared and then the character is applied. The clear is skipped for exactly one tick when the previous tick set the hold flag, and that flag is reset on the tick that skips the clear.
- R3: A mapped character replaces its whole word with the single bit shown here, given as word:mask:
  - space → 0:0x0001; CR (0x0D) and LF (0x0A) → 0:0x0040; backspace (0x08) → 4:0x0010
  - 'o' → 0:0x8000; '.' → 0:0x4000; 'a' → 1:0x8000; 'c' → 1:0x0020; 'x' → 1:0x0040; 'z' → 1:0x0080; 'k' → 3:0x0001; 'p' → 4:0x0020
  - '1' to '4' → 3:0x0080, 3:0x0040, 3:0x0020, 3:0x0010
  - '5' to '8' → 2:0x0008, 2:0x0004, 2:0x0002, 2:0x0001
  - '9' → 2:0x8000; '0' → 2:0x4000
- R4: An uppercase letter 'A' to 'Z' sets word 5 to 0x0800 (the shift bit) and sets the hold flag. It then re-injects the same letter plus 32.
- R5: A byte from 1 to 26 that R3 does not map sets word 5 to 0x0004 (the control bit) and sets the hold flag. It then re-injects the byte plus 96.
- R6: Shifted punctuation sets word 5 to 0x0800 without setting the hold flag, and re-injects the unshifted key. Examples are '!' → '1', '+' → '=', '?' → '/' and '"' → '''.
- R7: Byte 0x1B starts an escape sequence. After it, '[' continues the sequence and any other byte ends it. After '[', the letters 'A', 'B', 'C' and 'D' set word 0 to 0x1000, 0x2000, 0x0020 and 0x0010 respectively; any byte in that position ends the sequence. Bytes taken inside a sequence set no other key.
- R8: `key_event_o` pulses in the cycle after a scan tick if any word was nonzero before that tick's clear, or if a character was taken and the escape machine is idle after it.
- R9: A re-injected character is applied on the next scan tick, before any new input. `in_ready` stays low while the slot is full.
- R10: A byte with no mapping is taken and leaves all words zero for that tick.
- R11: The matrix words do not change in cycles without a scan tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle pulse that starts a scan period |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block takes the byte in this cycle |
| in_data | input | 8 | ASCII byte |
| mat_o | output | 96 | Matrix; word k is bits 16k+15 down to 16k |
| key_event_o | output | 1 | One-cycle pulse when a tick changes the key state |

## Verification
The bench builds the block with its default parameters: six words of 16 bits and 8-bit characters. These values make every placement that the layout names observable on `mat_o`. They also expose the modifier word, so the effect of the hold flag is visible on the pins. The single-entry slot lets back-pressure be tested directly, by offering a new byte on the tick after a modifier character and seeing it refused.

// File: rtl/akm_pkg.sv
package akm_pkg;
  localparam int unsigned CHW = 8;
  localparam int unsigned MOD_ROW = 5;
  localparam int unsigned SHIFT_COL = 11;
  localparam int unsigned CTRL_COL = 2;
  localparam int unsigned NAV_ROW = 0;
  localparam logic [CHW-1:0] ESC_CH = 8'h1B;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_OPEN, SEQ_CSI} seq_t;

  typedef struct packed {
    logic       hit;
    logic [2:0] row;
    logic [3:0] col;
  } keypos_t;

  typedef struct packed {
    logic           hit;
    logic [CHW-1:0] base;
  } shifted_t;

  function automatic keypos_t kp(input int r, input int c);
    kp.hit = 1'b1;
    kp.row = 3'(r);
    kp.col = 4'(c);
  endfunction

  function automatic keypos_t key_lookup(input logic [CHW-1:0] ch);
    keypos_t k = '0;
    case (ch)
      " ":   k = kp(0, 0);   8'h0D: k = kp(0, 6);  8'h0A: k = kp(0, 6);
      "]":   k = kp(0, 1);   "\\":  k = kp(0, 2);  "/":   k = kp(0, 3);
      "l":   k = kp(0, 7);   "[":   k = kp(0, 9);  "'":   k = kp(0, 10);
      ";":   k = kp(0, 11);  ".":   k = kp(0, 14); "o":   k = kp(0, 15);
      "v":   k = kp(1, 4);   "c":   k = kp(1, 5);  "x":   k = kp(1, 6);
      "z":   k = kp(1, 7);   "=":   k = kp(1, 9);  "-":   k = kp(1, 10);
      "f":   k = kp(1, 12);  "d":   k = kp(1, 13); "s":   k = kp(1, 14);
      "a":   k = kp(1, 15);
      "8":   k = kp(2, 0);   "7":   k = kp(2, 1);  "6":   k = kp(2, 2);
      "5":   k = kp(2, 3);   "r":   k = kp(2, 4);  "e":   k = kp(2, 5);
      "w":   k = kp(2, 6);   "q":   k = kp(2, 7);  ",":   k = kp(2, 8);
      "m":   k = kp(2, 9);   "n":   k = kp(2, 10); "b":   k = kp(2, 11);
      "0":   k = kp(2, 14);  "9":   k = kp(2, 15);
      "k":   k = kp(3, 0);   "j":   k = kp(3, 1);  "h":   k = kp(3, 2);
      "g":   k = kp(3, 3);   "4":   k = kp(3, 4);  "3":   k = kp(3, 5);
      "2":   k = kp(3, 6);   "1":   k = kp(3, 7);  "i":   k = kp(3, 8);
      "u":   k = kp(3, 9);   "y":   k = kp(3, 10); "t":   k = kp(3, 11);
      8'h08: k = kp(4, 4);   "p":   k = kp(4, 5);
      default: k = '0;
    endcase
    return k;
  endfunction

  function automatic shifted_t shift_lookup(input logic [CHW-1:0] ch);
    shifted_t s;
    s.hit = 1'b1;
    case (ch)
      "!": s.base = "1";  "@": s.base = "2";  "#": s.base = "3";
      "$": s.base = "4";  "%": s.base = "5";  "^": s.base = "6";
      "&": s.base = "7";  "*": s.base = "8";  "(": s.base = "9";
      ")": s.base = "0";  "+": s.base = "=";  "_": s.base = "-";
      "<": s.base = ",";  ">": s.base = ".";  "{": s.base = "[";
      "}": s.base = "]";  ":": s.base = ";";  "\"": s.base = "'";
      "|": s.base = "\\"; "?": s.base = "/";
      default: begin s.hit = 1'b0; s.base = '0; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/akm_decode.sv
module akm_decode
  import akm_pkg::*;
#(
  parameter int unsigned CH_W = 8
) (
  input  logic [CH_W-1:0] ch,
  output logic            key_hit,
  output logic [2:0]      key_row,
  output logic [3:0]      key_col,
  output logic            mod_hit,
  output logic [3:0]      mod_col,
  output logic            hold_set,
  output logic            requeue,
  output logic [CH_W-1:0] requeue_ch
);
  keypos_t  kpos;
  shifted_t sh;
  logic is_upper, is_ctrl;

  always_comb begin
    kpos     = key_lookup(CHW'(ch));
    sh       = shift_lookup(CHW'(ch));
    is_upper = (ch >= CH_W'("A")) && (ch <= CH_W'("Z"));
    is_ctrl  = (ch >= CH_W'(1)) && (ch <= CH_W'(26));
    key_hit    = kpos.hit;
    key_row    = kpos.row;
    key_col    = kpos.col;
    mod_hit    = 1'b0;
    mod_col    = 4'(SHIFT_COL);
    hold_set   = 1'b0;
    requeue    = 1'b0;
    requeue_ch = '0;
    if (!kpos.hit) begin
      if (sh.hit) begin
        mod_hit    = 1'b1;
        requeue    = 1'b1;
        requeue_ch = CH_W'(sh.base);
      end else if (is_upper) begin
        mod_hit    = 1'b1;
        hold_set   = 1'b1;
        requeue    = 1'b1;
        requeue_ch = ch + CH_W'(32);
      end else if (is_ctrl) begin
        mod_hit    = 1'b1;
        mod_col    = 4'(CTRL_COL);
        hold_set   = 1'b1;
        requeue    = 1'b1;
        requeue_ch = ch + CH_W'(96);
      end
    end
  end
endmodule

// File: rtl/akm_escseq.sv
module akm_escseq
  import akm_pkg::*;
#(
  parameter int unsigned CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [CH_W-1:0] ch,
  output logic            busy,
  output logic            ends_idle,
  output logic            arrow_hit,
  output logic [3:0]      arrow_col
);
  seq_t st_q, st_d;

  always_comb begin
    st_d      = st_q;
    arrow_hit = 1'b0;
    arrow_col = '0;
    unique case (st_q)
      SEQ_IDLE: if (ch == CH_W'(ESC_CH)) st_d = SEQ_OPEN;
      SEQ_OPEN: st_d = (ch == CH_W'("[")) ? SEQ_CSI : SEQ_IDLE;
      default: begin
        st_d      = SEQ_IDLE;
        arrow_hit = 1'b1;
        case (ch)
          CH_W'("A"): arrow_col = 4'd12;
          CH_W'("B"): arrow_col = 4'd13;
          CH_W'("C"): arrow_col = 4'd5;
          CH_W'("D"): arrow_col = 4'd4;
          default:    arrow_hit = 1'b0;
        endcase
      end
    endcase
  end

  assign busy      = (st_q != SEQ_IDLE);
  assign ends_idle = (st_d == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n)   st_q <= SEQ_IDLE;
    else if (adv) st_q <= st_d;
  end
endmodule

// File: rtl/akm_slot.sv
module akm_slot #(
  parameter int unsigned CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] load_ch,
  input  logic            drain,
  output logic            full,
  output logic [CH_W-1:0] ch
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      ch   <= '0;
    end else if (load) begin
      full <= 1'b1;
      ch   <= load_ch;
    end else if (drain) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/ascii_keymatrix.sv
module ascii_keymatrix
  import akm_pkg::*;
#(
  parameter int unsigned ROWS  = 6,
  parameter int unsigned ROW_W = 16,
  parameter int unsigned CH_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_tick,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [CH_W-1:0]       in_data,
  output logic [ROWS*ROW_W-1:0] mat_o,
  output logic                  key_event_o
);
  localparam int unsigned MAT_W = ROWS * ROW_W;

  logic [ROW_W-1:0] mat_q [ROWS];
  logic [ROW_W-1:0] mat_d [ROWS];
  logic             hold_q, hold_d;
  logic             slot_full;
  logic [CH_W-1:0]  slot_ch, cur_ch, rq_ch;
  logic             take, any_set;
  logic             key_hit, mod_hit, hold_set, rq;
  logic [2:0]       key_row;
  logic [3:0]       key_col, mod_col, arrow_col;
  logic             esc_busy, esc_ends_idle, arrow_hit;

  assign in_ready = scan_tick && !slot_full;
  assign take     = scan_tick && (slot_full || in_valid);
  assign cur_ch   = slot_full ? slot_ch : in_data;
  assign any_set  = |mat_o;

  akm_decode #(.CH_W(CH_W)) dec_i (
    .ch(cur_ch), .key_hit(key_hit), .key_row(key_row), .key_col(key_col),
    .mod_hit(mod_hit), .mod_col(mod_col), .hold_set(hold_set),
    .requeue(rq), .requeue_ch(rq_ch)
  );

  akm_escseq #(.CH_W(CH_W)) esc_i (
    .clk(clk), .rst_n(rst_n), .adv(take), .ch(cur_ch), .busy(esc_busy),
    .ends_idle(esc_ends_idle), .arrow_hit(arrow_hit), .arrow_col(arrow_col)
  );

  akm_slot #(.CH_W(CH_W)) slot_i (
    .clk(clk), .rst_n(rst_n), .load(take && !esc_busy && rq),
    .load_ch(rq_ch), .drain(scan_tick && slot_full),
    .full(slot_full), .ch(slot_ch)
  );

  always_comb begin
    for (int r = 0; r < ROWS; r++) mat_d[r] = hold_q ? mat_q[r] : '0;
    hold_d = 1'b0;
    if (take) begin
      if (esc_busy) begin
        if (arrow_hit) mat_d[NAV_ROW] = ROW_W'(1) << arrow_col;
      end else if (key_hit) begin
        mat_d[key_row] = ROW_W'(1) << key_col;
      end else if (mod_hit) begin
        mat_d[MOD_ROW] = ROW_W'(1) << mod_col;
        hold_d = hold_set;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mat_q[r] <= '0;
      hold_q      <= 1'b0;
      key_event_o <= 1'b0;
    end else begin
      key_event_o <= scan_tick && (any_set || (take && esc_ends_idle));
      if (scan_tick) begin
        for (int r = 0; r < ROWS; r++) mat_q[r] <= mat_d[r];
        hold_q <= hold_d;
      end
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_pack
    assign mat_o[g*ROW_W +: ROW_W] = mat_q[g];
  end

  logic unused_ok;
  assign unused_ok = ^{MAT_W[0]};
endmodule

// File: rtl/akm_chk.sv
module akm_chk #(
  parameter int unsigned MAT_W = 96,
  parameter int unsigned CH_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_tick,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CH_W-1:0]  in_data,
  input logic [MAT_W-1:0] mat_o,
  input logic             key_event_o,
  input logic             esc_busy
);
  logic up_taken, esc_taken;
  assign up_taken  = scan_tick && in_valid && in_ready && !esc_busy &&
                     (in_data >= CH_W'("A")) && (in_data <= CH_W'("Z"));
  assign esc_taken = scan_tick && in_valid && in_ready && !esc_busy &&
                     (in_data == CH_W'(8'h1B));

  // R8
  event_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_event_o |-> $past(scan_tick));
  // R11
  quiet_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(mat_o));
  // R9
  slot_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_taken |=> !in_ready);
  // R7
  esc_sets_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_taken |=> (mat_o == '0));
  // R2
  key_plus_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mat_o) <= 2);
endmodule

bind ascii_keymatrix akm_chk #(.MAT_W(ROWS*ROW_W), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .in_valid(in_valid),
  .in_ready(in_ready), .in_data(in_data), .mat_o(mat_o),
  .key_event_o(key_event_o), .esc_busy(esc_busy)
);

// File: tb/ascii_keymatrix_tb_top.sv
module ascii_keymatrix_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, scan_tick = 1'b0, in_valid = 1'b0;
  logic in_ready, key_event_o;
  logic [7:0] in_data = '0;
  logic [95:0] mat_o;
  int total = 0, bad = 0;
  logic rdy_seen;
  bit done = 0;

  always #5 clk = ~clk;

  ascii_keymatrix dut_i (.*);

  // {char, word index, mask} for R3 placements
  localparam int NV = 16;
  localparam logic [31:0] VEC [NV] = '{
    {8'h20, 8'd0, 16'h0001}, {8'h0D, 8'd0, 16'h0040}, {8'h0A, 8'd0, 16'h0040},
    {8'h08, 8'd4, 16'h0010}, {"a",   8'd1, 16'h8000}, {"o",   8'd0, 16'h8000},
    {"p",   8'd4, 16'h0020}, {"1",   8'd3, 16'h0080}, {"4",   8'd3, 16'h0010},
    {"5",   8'd2, 16'h0008}, {"8",   8'd2, 16'h0001}, {"9",   8'd2, 16'h8000},
    {"0",   8'd2, 16'h4000}, {".",   8'd0, 16'h4000}, {"k",   8'd3, 16'h0001},
    {"z",   8'd1, 16'h0080}
  };

  function automatic logic [95:0] w(input int r, input logic [15:0] m);
    logic [95:0] v = '0;
    v[r*16 +: 16] = m;
    return v;
  endfunction

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic v, input logic [7:0] d);
    @(negedge clk);
    scan_tick = 1'b1; in_valid = v; in_data = d;
    #1 rdy_seen = in_ready;
    @(negedge clk);
    scan_tick = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 matrix", mat_o, '0);
    check("R1 event", 96'(key_event_o), 96'(0));
    check("R9 ready low without tick", 96'(in_ready), 96'(0));

    for (int i = 0; i < NV; i++) begin
      tick(1'b1, VEC[i][31:24]);
      check("R3 placement", mat_o, w(int'(VEC[i][23:16]), VEC[i][15:0]));
      check("R8 event on key", 96'(key_event_o), 96'(1));
    end

    // R10 unmapped '~'
    tick(1'b1, 8'h7E);
    check("R10 unmapped clears", mat_o, '0);
    check("R8 event unmapped", 96'(key_event_o), 96'(1));
    tick(1'b0, 8'h00);
    check("R8 no event idle", 96'(key_event_o), 96'(0));

    // R4 uppercase with hold and R9 back-pressure
    tick(1'b1, "A");
    check("R4 shift bit", mat_o, w(5, 16'h0800));
    tick(1'b1, "z");
    check("R9 ready low while slot full", 96'(rdy_seen), 96'(0));
    check("R4 hold keeps shift, adds a", mat_o, w(5, 16'h0800) | w(1, 16'h8000));
    repeat (5) @(negedge clk);
    check("R11 stable between ticks", mat_o, w(5, 16'h0800) | w(1, 16'h8000));
    tick(1'b1, "z");
    check("R9 held byte taken later", 96'(rdy_seen), 96'(1));
    check("R2 hold used once", mat_o, w(1, 16'h0080));

    // R5 control
    tick(1'b1, 8'h03);
    check("R5 ctrl bit", mat_o, w(5, 16'h0004));
    tick(1'b0, 8'h00);
    check("R5 ctrl plus c", mat_o, w(5, 16'h0004) | w(1, 16'h0020));

    // R6 shifted punctuation: no hold
    tick(1'b1, "!");
    check("R6 shift bit", mat_o, w(5, 16'h0800));
    tick(1'b0, 8'h00);
    check("R6 base key without hold", mat_o, w(3, 16'h0080));
    tick(1'b1, "?");
    tick(1'b0, 8'h00);
    check("R6 question to slash", mat_o, w(0, 16'h0008));

    // R7 escape sequences
    tick(1'b0, 8'h00);
    tick(1'b0, 8'h00);
    tick(1'b1, 8'h1B);
    check("R7 esc sets nothing", mat_o, '0);
    check("R8 no event inside esc", 96'(key_event_o), 96'(0));
    tick(1'b1, "[");
    check("R8 no event on bracket", 96'(key_event_o), 96'(0));
    tick(1'b1, "A");
    check("R7 up arrow", mat_o, w(0, 16'h1000));
    check("R8 event on arrow", 96'(key_event_o), 96'(1));
    tick(1'b1, 8'h1B); tick(1'b1, "["); tick(1'b1, "D");
    check("R7 left arrow", mat_o, w(0, 16'h0010));
    tick(1'b1, 8'h1B);
    check("R8 event from prior key", 96'(key_event_o), 96'(1));
    tick(1'b1, "x");
    check("R7 abort in open state", mat_o, '0);
    check("R8 event on abort", 96'(key_event_o), 96'(1));
    tick(1'b1, "x");
    check("R7 back to idle", mat_o, w(1, 16'h0040));
    tick(1'b1, 8'h1B); tick(1'b1, "["); tick(1'b1, "Z");
    check("R7 unknown final byte", mat_o, '0);
    tick(1'b1, "a");
    check("R7 idle after unknown", mat_o, w(1, 16'h8000));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule